// File: doc/BRIEF.md
# Indirect Pointer Address Unit

This unit turns a 16-bit register-pair pointer into a memory address for an 8-bit processor core. The pointer is built from a high-byte and a low-byte register value. A mode code picks one of five access styles. In plain indirect, the pointer is the address as it is. In post-increment, the current pointer is the address and the pointer then steps up by one. In pre-decrement, the pointer first steps down by one and that value is the address. In displacement, the address is the pointer plus a small unsigned offset. In program-memory constant fetch, the pointer is split into a 16-bit word address and a byte select.

The core pulses `start` for one cycle with the pointer, the mode and the displacement. One clock later the unit presents the address together with a data-access or program-access strobe. For the two stepping modes it also presents an updated pointer, split into bytes, with a one-cycle write-back enable that the register file uses to store it. The register file and the memories sit outside this block.

Top module: `ptr_addr_unit`

## Requirements
- R1: The pointer is `{ptr_hi, ptr_lo}`. For mode code 0 (plain), `data_req` is 1 and `addr` equals the pointer; `wb_en` stays 0.
- R2: For mode code 1 (post-increment), `addr` equals the pointer, `wb_en` is 1 and `{wb_hi, wb_lo}` equals the pointer plus one.
- R3: For mode code 2 (pre-decrement), `addr` and `{wb_hi, wb_lo}` both equal the pointer minus one, and `wb_en` is 1.
- R4: For mode code 3 (displacement), `addr` equals the pointer plus `disp`, where `disp` is an unsigned 6-bit value (0 to 63). `wb_en` stays 0.
- R5: For mode code 4 (program fetch), `prog_req` is 1 instead of `data_req`. `addr` is `{1'b0, pointer[15:1]}` and `byte_hi` equals pointer bit 0, where 0 means the low byte and 1 the high byte. `wb_en` stays 0. `byte_hi` is 0 outside program fetches.
- R6: All pointer arithmetic wraps modulo 2^16. For example, 0x0000 pre-decremented gives 0xFFFF, 0xFFFF post-incremented gives 0x0000, and 0xFFF0 plus 63 gives 0x002F.
- R7: The results appear on the clock edge after the one that samples `start` high. The strobes `data_req`, `prog_req` and `wb_en` are high for that one cycle only, unless `start` is high again. On idle cycles `addr`, `byte_hi` and the write-back bytes hold their values.
- R8: Mode codes 5, 6 and 7 are reserved. A start with one of them raises no strobe and leaves `addr`, `byte_hi` and the write-back bytes unchanged.
- R9: Reset is synchronous and active-low. It clears every strobe, `addr`, `byte_hi` and the write-back bytes.
- R10: The pointer starts at 0x0060 and each write-back is stored into the register pair. The sequence post-increment, plain, reload to 0x0063, plain, pre-decrement then accesses 0x60, 0x61, 0x63 and 0x62 in that order, and leaves the pointer at 0x0062.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, one cycle per access |
| mode | input | 3 | Access mode code (0 to 4; 5 to 7 reserved) |
| ptr_lo | input | 8 | Pointer low byte |
| ptr_hi | input | 8 | Pointer high byte |
| disp | input | 6 | Unsigned displacement |
| data_req | output | 1 | Data-space access strobe |
| prog_req | output | 1 | Program-memory access strobe |
| addr | output | 16 | Effective data address, or word address for program fetch |
| byte_hi | output | 1 | Byte select for program fetch |
| wb_en | output | 1 | Pointer write-back enable |
| wb_lo | output | 8 | Updated pointer low byte |
| wb_hi | output | 8 | Updated pointer high byte |

## Verification
A wrong arithmetic path or a wrong mode decode in this block shows at the ports in the very next cycle after `start`. It appears as an address off by one or by the displacement, a missing or extra write-back pulse, or a strobe on the wrong memory space. The state left behind by a fault matters too. A write-back value that is off by one, or a register that fails to hold on idle cycles, only surfaces in the following accesses of a chained sequence such as R10. The bench therefore compares every output on every clock against a behavioural model, and it also runs chained pointer sequences that feed the write-back into the next request.

// File: rtl/ptr_pkg.sv
// Shared types for the indirect pointer address unit.
// Assumes mode codes 0..4 are defined and 5..7 are reserved.
package ptr_pkg;

    typedef enum logic [2:0] {
        PM_PLAIN   = 3'd0,
        PM_POSTINC = 3'd1,
        PM_PREDEC  = 3'd2,
        PM_DISP    = 3'd3,
        PM_PROG    = 3'd4
    } pmode_e;

    // Which computed value drives the address output
    typedef enum logic [1:0] {
        AS_PTR  = 2'd0,
        AS_DEC  = 2'd1,
        AS_DISP = 2'd2,
        AS_WORD = 2'd3
    } addr_sel_e;

    // Which computed value drives the write-back output
    typedef enum logic {
        WS_INC = 1'b0,
        WS_DEC = 1'b1
    } wb_sel_e;

    typedef struct packed {
        logic      data_acc;
        logic      prog_acc;
        logic      wb;
        addr_sel_e asel;
        wb_sel_e   wsel;
    } pctl_t;

endpackage

// File: rtl/ptr_mode_decode.sv
// Mode decoder: maps the 3-bit mode code onto access, write-back and
// select controls. Assumes reserved codes must produce no access at all.
module ptr_mode_decode
    import ptr_pkg::*;
(
    input  logic [2:0] mode,
    output pctl_t      ctl
);

    // Purpose: translate the mode code into control fields
    always_comb begin
        ctl = '{data_acc: 1'b0, prog_acc: 1'b0, wb: 1'b0,
                asel: AS_PTR, wsel: WS_INC};
        case (mode)
            PM_PLAIN: begin
                ctl.data_acc = 1'b1;
            end
            PM_POSTINC: begin
                ctl.data_acc = 1'b1;
                ctl.wb       = 1'b1;
                ctl.wsel     = WS_INC;
            end
            PM_PREDEC: begin
                ctl.data_acc = 1'b1;
                ctl.wb       = 1'b1;
                ctl.asel     = AS_DEC;
                ctl.wsel     = WS_DEC;
            end
            PM_DISP: begin
                ctl.data_acc = 1'b1;
                ctl.asel     = AS_DISP;
            end
            PM_PROG: begin
                ctl.prog_acc = 1'b1;
                ctl.asel     = AS_WORD;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ptr_arith.sv
// Pointer arithmetic: joins the pointer bytes and computes the stepped,
// displaced and word-split forms. All sums wrap modulo 2^PTR_W.
// Assumes the pointer is NBYTES little-endian bytes of BYTE_W bits.
module ptr_arith #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    parameter int DISP_W = 6,
    localparam int PTR_W = BYTE_W * NBYTES
) (
    input  logic [NBYTES-1:0][BYTE_W-1:0] ptr_bytes,
    input  logic [DISP_W-1:0]             disp,
    output logic [PTR_W-1:0]              ptr,
    output logic [PTR_W-1:0]              ptr_inc,
    output logic [PTR_W-1:0]              ptr_dec,
    output logic [PTR_W-1:0]              ptr_disp,
    output logic [PTR_W-1:0]              word_addr,
    output logic                          byte_sel
);

    localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    // Purpose: concatenate the register bytes, lowest byte at bit 0
    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_join
        assign ptr[gi*BYTE_W +: BYTE_W] = ptr_bytes[gi];
    end

    // Purpose: step, displacement and program-word forms of the pointer
    always_comb begin
        ptr_inc   = ptr + ONE;
        ptr_dec   = ptr - ONE;
        ptr_disp  = ptr + {{(PTR_W-DISP_W){1'b0}}, disp};
        word_addr = {1'b0, ptr[PTR_W-1:1]};
        byte_sel  = ptr[0];
    end

endmodule

// File: rtl/ptr_select.sv
// Output selector: picks the address and write-back values named by
// the decoded controls. Assumes all candidate values are already computed.
module ptr_select
    import ptr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  pctl_t            ctl,
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] ptr_inc,
    input  logic [PTR_W-1:0] ptr_dec,
    input  logic [PTR_W-1:0] ptr_disp,
    input  logic [PTR_W-1:0] word_addr,
    input  logic             byte_sel,
    output logic [PTR_W-1:0] addr_nx,
    output logic [PTR_W-1:0] wb_nx,
    output logic             bh_nx
);

    // Purpose: address multiplexer
    always_comb begin
        case (ctl.asel)
            AS_DEC:  addr_nx = ptr_dec;
            AS_DISP: addr_nx = ptr_disp;
            AS_WORD: addr_nx = word_addr;
            default: addr_nx = ptr;
        endcase
    end

    // Purpose: write-back value and byte-select for program fetch
    always_comb begin
        wb_nx = (ctl.wsel == WS_DEC) ? ptr_dec : ptr_inc;
        bh_nx = ctl.prog_acc & byte_sel;
    end

endmodule

// File: rtl/ptr_out_stage.sv
// Output register stage: loads results on an accepted request and holds
// them otherwise; strobes last one cycle. Synchronous active-low reset.
// Assumes a request with no access control set is a reserved code.
module ptr_out_stage
    import ptr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  pctl_t            ctl,
    input  logic [PTR_W-1:0] addr_nx,
    input  logic [PTR_W-1:0] wb_nx,
    input  logic             bh_nx,
    output logic             data_req,
    output logic             prog_req,
    output logic             wb_en,
    output logic [PTR_W-1:0] addr_q,
    output logic [PTR_W-1:0] wb_q,
    output logic             bh_q
);

    logic take;
    assign take = start & (ctl.data_acc | ctl.prog_acc);

    // Purpose: one-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_req <= 1'b0;
            prog_req <= 1'b0;
            wb_en    <= 1'b0;
        end else begin
            data_req <= start & ctl.data_acc;
            prog_req <= start & ctl.prog_acc;
            wb_en    <= start & ctl.wb;
        end
    end

    // Purpose: address and write-back values, held between requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wb_q   <= '0;
            bh_q   <= 1'b0;
        end else if (take) begin
            addr_q <= addr_nx;
            bh_q   <= bh_nx;
            if (ctl.wb) begin
                wb_q <= wb_nx;
            end
        end
    end

    // R7: no strobe without a start on the previous edge
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start) |-> !data_req && !prog_req && !wb_en);

    // R7: address holds over a cycle with no strobe
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start) && $past(rst_n) |-> $stable(addr_q));

    // R5: the two memory spaces are never requested together
    p_space_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({data_req, prog_req}) <= 1);

    // R5: program fetch never writes the pointer back
    p_prog_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !wb_en);

    // R2: write-back always comes with a data access
    p_wb_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> data_req);

    // R3: written-back pointer is the address or one above it
    p_wb_near_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_q == addr_q) ||
                  (wb_q == addr_q + {{(PTR_W-1){1'b0}}, 1'b1}));

    // R5: byte select only raised on a program fetch
    p_bh_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) && !prog_req && (data_req) |-> !bh_q);

endmodule

// File: rtl/ptr_addr_unit.sv
// Indirect pointer address unit (top). Forms the effective address from a
// register-pair pointer for plain, post-increment, pre-decrement,
// displacement and program-fetch accesses, and returns the updated pointer.
// Assumes one request per start pulse; results appear one clock later.
module ptr_addr_unit
    import ptr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DISP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [BYTE_W-1:0] ptr_lo,
    input  logic [BYTE_W-1:0] ptr_hi,
    input  logic [DISP_W-1:0] disp,
    output logic              data_req,
    output logic              prog_req,
    output logic [2*BYTE_W-1:0] addr,
    output logic              byte_hi,
    output logic              wb_en,
    output logic [BYTE_W-1:0] wb_lo,
    output logic [BYTE_W-1:0] wb_hi
);

    localparam int NBYTES = 2;
    localparam int PTR_W  = BYTE_W * NBYTES;

    pctl_t                        ctl;
    logic [NBYTES-1:0][BYTE_W-1:0] ptr_bytes;
    logic [PTR_W-1:0] ptr, ptr_inc, ptr_dec, ptr_disp, word_addr;
    logic [PTR_W-1:0] addr_nx, wb_nx, wb_q;
    logic             byte_sel, bh_nx;

    assign ptr_bytes[0] = ptr_lo;
    assign ptr_bytes[1] = ptr_hi;

    ptr_mode_decode u_dec (
        .mode (mode),
        .ctl  (ctl)
    );

    ptr_arith #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .DISP_W(DISP_W)) u_arith (
        .ptr_bytes (ptr_bytes),
        .disp      (disp),
        .ptr       (ptr),
        .ptr_inc   (ptr_inc),
        .ptr_dec   (ptr_dec),
        .ptr_disp  (ptr_disp),
        .word_addr (word_addr),
        .byte_sel  (byte_sel)
    );

    ptr_select #(.PTR_W(PTR_W)) u_sel (
        .ctl       (ctl),
        .ptr       (ptr),
        .ptr_inc   (ptr_inc),
        .ptr_dec   (ptr_dec),
        .ptr_disp  (ptr_disp),
        .word_addr (word_addr),
        .byte_sel  (byte_sel),
        .addr_nx   (addr_nx),
        .wb_nx     (wb_nx),
        .bh_nx     (bh_nx)
    );

    ptr_out_stage #(.PTR_W(PTR_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ctl      (ctl),
        .addr_nx  (addr_nx),
        .wb_nx    (wb_nx),
        .bh_nx    (bh_nx),
        .data_req (data_req),
        .prog_req (prog_req),
        .wb_en    (wb_en),
        .addr_q   (addr),
        .wb_q     (wb_q),
        .bh_q     (byte_hi)
    );

    // Purpose: split the write-back pointer into register bytes
    assign wb_lo = wb_q[BYTE_W-1:0];
    assign wb_hi = wb_q[PTR_W-1:BYTE_W];

    // R8: a reserved code raises nothing on the next edge
    p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && (mode > 3'd4) |=> !data_req && !prog_req && !wb_en);

    // R1: a plain start gives an address equal to the sampled pointer
    p_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start && (mode == 3'd0) |=> data_req && !wb_en &&
                                    (addr == $past({ptr_hi, ptr_lo})));

endmodule

// File: tb/ptr_addr_unit_test.sv
`timescale 1ns/1ps
module ptr_addr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [7:0]  ptr_lo = 8'h00, ptr_hi = 8'h00;
    logic [5:0]  disp = 6'd0;
    logic        data_req, prog_req, byte_hi, wb_en;
    logic [15:0] addr;
    logic [7:0]  wb_lo, wb_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected state of the reference model
    bit          e_data, e_prog, e_bh, e_wb;
    int          e_addr, e_wbv;
    string       e_tag = "R9";

    always #4 clk = ~clk;   // 125 MHz

    ptr_addr_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .disp(disp),
        .data_req(data_req), .prog_req(prog_req), .addr(addr),
        .byte_hi(byte_hi), .wb_en(wb_en), .wb_lo(wb_lo), .wb_hi(wb_hi)
    );

    // Behavioural reference model, updated on each rising edge
    always @(posedge clk) begin
        int p;
        p = {ptr_hi, ptr_lo};
        if (!rst_n) begin
            e_data = 0; e_prog = 0; e_wb = 0; e_bh = 0;
            e_addr = 0; e_wbv = 0; e_tag = "R9";
        end else begin
            e_data = 0; e_prog = 0; e_wb = 0;
            if (start) begin
                case (mode)
                    3'd0: begin e_data = 1; e_addr = p; e_bh = 0; e_tag = "R1"; end
                    3'd1: begin e_data = 1; e_wb = 1; e_addr = p; e_bh = 0;
                                e_wbv = (p + 1) % 65536; e_tag = "R2/R6"; end
                    3'd2: begin e_data = 1; e_wb = 1; e_bh = 0;
                                e_addr = (p + 65535) % 65536; e_wbv = e_addr;
                                e_tag = "R3/R6"; end
                    3'd3: begin e_data = 1; e_bh = 0;
                                e_addr = (p + int'(disp)) % 65536; e_tag = "R4/R6"; end
                    3'd4: begin e_prog = 1; e_addr = p / 2; e_bh = p[0];
                                e_tag = "R5"; end
                    default: e_tag = "R8";
                endcase
            end else begin
                e_tag = "R7";
            end
        end
    end

    // Compare every output on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (data_req !== e_data || prog_req !== e_prog || wb_en !== e_wb ||
                byte_hi !== e_bh || int'(addr) != e_addr ||
                int'({wb_hi, wb_lo}) != e_wbv) begin
                errors++;
                $display("FAIL %s: got req=%b prog=%b wb=%b bh=%b addr=%h wbv=%h exp req=%b prog=%b wb=%b bh=%b addr=%h wbv=%h",
                         e_tag, data_req, prog_req, wb_en, byte_hi, addr, {wb_hi, wb_lo},
                         e_data, e_prog, e_wb, e_bh, e_addr[15:0], e_wbv[15:0]);
            end
        end
    end

    task automatic do_op(input logic [2:0] m, input logic [15:0] p, input logic [5:0] d);
        @(negedge clk);
        start = 1'b1; mode = m; {ptr_hi, ptr_lo} = p; disp = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_val(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            done = 1'b1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;                       // R9 checked while low
        // R1..R5 directed
        do_op(3'd0, 16'h1234, 6'd0);        // R1
        check_val("R1", addr, 16'h1234);
        do_op(3'd1, 16'h00FF, 6'd0);        // R2 carry into high byte
        check_val("R2", {wb_hi, wb_lo}, 16'h0100);
        do_op(3'd2, 16'h0100, 6'd0);        // R3 borrow from high byte
        check_val("R3", addr, 16'h00FF);
        do_op(3'd3, 16'h2000, 6'd63);       // R4 largest displacement
        check_val("R4", addr, 16'h203F);
        do_op(3'd4, 16'h1235, 6'd0);        // R5 high byte of word 0x091A
        check_val("R5", {15'd0, byte_hi}, 1);
        check_val("R5", addr, 16'h091A);
        // R6 wrap cases
        do_op(3'd2, 16'h0000, 6'd0);
        check_val("R6", {wb_hi, wb_lo}, 16'hFFFF);
        do_op(3'd1, 16'hFFFF, 6'd0);
        check_val("R6", {wb_hi, wb_lo}, 16'h0000);
        do_op(3'd3, 16'hFFF0, 6'd63);
        check_val("R6", addr, 16'h002F);
        // R8 reserved codes: values held from the previous access
        for (int c = 5; c < 8; c++) begin
            do_op(3'(c), 16'hABCD, 6'd5);
            check_val("R8", addr, 16'h002F);
            check_val("R8", {15'd0, data_req | prog_req | wb_en}, 0);
        end
        // R7 back-to-back starts then idle
        @(negedge clk);
        start = 1'b1; mode = 3'd1; {ptr_hi, ptr_lo} = 16'h4000;
        @(negedge clk);
        {ptr_hi, ptr_lo} = 16'h4001;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check_val("R7", {15'd0, wb_en}, 0);
        check_val("R7", addr, 16'h4001);
        // R10 chained sequence, write-back stored into the pointer pair
        rp = 16'h0060;
        do_op(3'd1, rp, 6'd0); check_val("R10", addr, 16'h0060);
        if (wb_en) rp = {wb_hi, wb_lo};
        do_op(3'd0, rp, 6'd0); check_val("R10", addr, 16'h0061);
        rp = 16'h0063;
        do_op(3'd0, rp, 6'd0); check_val("R10", addr, 16'h0063);
        do_op(3'd2, rp, 6'd0); check_val("R10", addr, 16'h0062);
        if (wb_en) rp = {wb_hi, wb_lo};
        check_val("R10", rp, 16'h0062);
        // Random traffic, model compares every cycle
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            start = ($urandom % 3) != 0;
            mode = 3'($urandom % 8);
            {ptr_hi, ptr_lo} = 16'($urandom);
            disp = 6'($urandom);
        end
        // R9 reset in mid-run
        @(negedge clk);
        start = 1'b1; mode = 3'd1;
        rst_n = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check_val("R9", addr, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule